// File: doc/BRIEF.md
# Programmable Digital Input Glitch Filter

This block cleans up slow, noisy digital input lines such as relay contacts, push buttons and field wiring. Every line either passes its raw level straight through or goes through a stability filter. A filtered line takes on a new level only when the raw input has disagreed with the current filtered level at every tick of a programmed interval. The interval is a single value shared by all lines. It is counted in ticks of 200 ns, and the tick is derived from the system clock.

Lines are grouped into ports of eight. Each port has its own enable mask, so filtered and raw lines can sit side by side in the same port. Configuration arrives through a simple write strobe with an address and a 32-bit data word. The block expects its raw inputs to be already synchronised to the clock, and its outputs feed whatever logic follows, for example an edge detector.

Top module: `glitch_filter`

## Requirements
- R1: After reset, every enable mask and the interval are zero, so every output equals its raw input.
- R2: An internal tick strobe fires once every CLK_HZ / TICK_HZ clock cycles (25 cycles at 125 MHz, that is 200 ns). Filter counts advance only on this tick.
- R3: A line whose enable bit is 0 drives its output from the raw input in the same cycle.
- R4: A line whose enable bit is 1 passes its raw input straight through while the interval is zero.
- R5: With interval I > 0, an enabled line changes its output to the raw level on the cycle after the I-th consecutive tick at which the raw level differed from the output. Before that, the output holds.
- R6: If the raw level returns to the output level on any cycle, the count restarts. A disturbance that lasts fewer than I ticks never reaches the output.
- R7: A write to address 0 loads wr_data[19:0] as the interval for all lines. Bits 31:20 are ignored, so 0xFFF00002 gives an interval of 2.
- R8: A write to address 1+p loads wr_data[7:0] as the enable mask of port p. Bit b controls line 8*p+b, and filtered and unfiltered lines in one port work independently.
- R9: When a line's enable bit goes from 0 to 1, its filtered output starts at the raw level present at the time of the write and shows no spurious change.
- R10: Writes to any other address have no effect on masks or interval.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | ADDR_W | Register address (0 = interval, 1+p = mask of port p) |
| wr_data | input | 32 | Write data |
| raw_in | input | 8*NUM_PORTS | Synchronised raw input lines |
| filt_out | output | 8*NUM_PORTS | Filtered or passed-through lines |

## Verification
The assertions assume that raw_in changes only between clock edges and is already synchronous. They also assume that the configuration seen by a line is stable across the cycle pair being judged, so a level step is only required to follow a tick while the mask bit and the interval were unchanged in the previous cycle. The stimulus changes raw lines and issues writes on falling clock edges. It holds a line's raw level steady across the write that enables it. The timing checks use bounds that hold at any tick phase, so they do not depend on where the tick counter happens to be.

// File: rtl/glitch_filter_pkg.sv
package glitch_filter_pkg;
    localparam int LINES_PER_PORT = 8;
    localparam int IVL_W          = 20;
    localparam int DATA_W         = 32;
    localparam int ADDR_IVL       = 0;
    localparam int ADDR_MASK_BASE = 1;
    typedef logic [IVL_W-1:0] ivl_t;
endpackage

// File: rtl/gf_tick_gen.sv
module gf_tick_gen #(
    parameter int TICK_CYC = 25
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick
);
    localparam int CW = (TICK_CYC > 1) ? $clog2(TICK_CYC) : 1;
    localparam logic [CW-1:0] LAST = CW'(TICK_CYC - 1);

    typedef struct packed {
        logic [CW-1:0] cnt;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (st_q.cnt == LAST) st_d.cnt = '0;
        else                  st_d.cnt = st_q.cnt + 1'b1;
        tick = (st_q.cnt == LAST);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end
endmodule

// File: rtl/gf_regs.sv
module gf_regs
    import glitch_filter_pkg::*;
#(
    parameter int NUM_PORTS = 2,
    parameter int ADDR_W    = 8
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              wr_en,
    input  logic [ADDR_W-1:0]                 wr_addr,
    input  logic [DATA_W-1:0]                 wr_data,
    output ivl_t                              interval,
    output logic [NUM_PORTS*LINES_PER_PORT-1:0] mask
);
    localparam int NL = NUM_PORTS * LINES_PER_PORT;

    typedef struct packed {
        ivl_t          ivl;
        logic [NL-1:0] msk;
    } st_t;

    st_t st_d, st_q;
    logic unused_hi;

    assign unused_hi = ^wr_data[DATA_W-1:IVL_W];

    always_comb begin
        st_d = st_q;
        if (wr_en) begin
            if (wr_addr == ADDR_W'(ADDR_IVL))
                st_d.ivl = wr_data[IVL_W-1:0];
            for (int p = 0; p < NUM_PORTS; p++) begin
                if (wr_addr == ADDR_W'(ADDR_MASK_BASE + p))
                    st_d.msk[p*LINES_PER_PORT +: LINES_PER_PORT] = wr_data[LINES_PER_PORT-1:0];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign interval = st_q.ivl;
    assign mask     = st_q.msk;
endmodule

// File: rtl/gf_line_cell.sv
module gf_line_cell
    import glitch_filter_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic enable,
    input  ivl_t interval,
    input  logic raw,
    output logic filt
);
    typedef struct packed {
        logic lvl;
        ivl_t cnt;
    } st_t;

    st_t  st_d, st_q;
    logic pass;

    always_comb begin
        st_d = st_q;
        pass = !enable || (interval == '0);
        if (pass) begin
            st_d.lvl = raw;
            st_d.cnt = '0;
        end else if (raw == st_q.lvl) begin
            st_d.cnt = '0;
        end else if (tick) begin
            if (({1'b0, st_q.cnt} + 1'b1) >= {1'b0, interval}) begin
                st_d.lvl = raw;
                st_d.cnt = '0;
            end else begin
                st_d.cnt = st_q.cnt + 1'b1;
            end
        end
        filt = pass ? raw : st_q.lvl;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end
endmodule

// File: rtl/glitch_filter.sv
module glitch_filter
    import glitch_filter_pkg::*;
#(
    parameter int NUM_PORTS = 2,
    parameter int ADDR_W    = 8,
    parameter int CLK_HZ    = 125_000_000,
    parameter int TICK_HZ   = 5_000_000
) (
    input  logic                                clk,
    input  logic                                rst_n,
    input  logic                                wr_en,
    input  logic [ADDR_W-1:0]                   wr_addr,
    input  logic [31:0]                         wr_data,
    input  logic [NUM_PORTS*LINES_PER_PORT-1:0] raw_in,
    output logic [NUM_PORTS*LINES_PER_PORT-1:0] filt_out
);
    localparam int NL       = NUM_PORTS * LINES_PER_PORT;
    localparam int TICK_CYC = (CLK_HZ / TICK_HZ > 0) ? CLK_HZ / TICK_HZ : 1;

    logic          tick;
    ivl_t          interval;
    logic [NL-1:0] mask;

    gf_tick_gen #(.TICK_CYC(TICK_CYC)) u_tick (
        .clk  (clk),
        .rst_n(rst_n),
        .tick (tick)
    );

    gf_regs #(.NUM_PORTS(NUM_PORTS), .ADDR_W(ADDR_W)) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .interval(interval),
        .mask    (mask)
    );

    for (genvar i = 0; i < NL; i++) begin : g_line
        gf_line_cell u_cell (
            .clk     (clk),
            .rst_n   (rst_n),
            .tick    (tick),
            .enable  (mask[i]),
            .interval(interval),
            .raw     (raw_in[i]),
            .filt    (filt_out[i])
        );
    end
endmodule

// File: rtl/glitch_filter_chk.sv
module glitch_filter_chk
    import glitch_filter_pkg::*;
#(
    parameter int NUM_PORTS = 2,
    parameter int ADDR_W    = 8,
    parameter int TICK_CYC  = 25
) (
    input logic                                clk,
    input logic                                rst_n,
    input logic                                wr_en,
    input logic [ADDR_W-1:0]                   wr_addr,
    input logic [31:0]                         wr_data,
    input logic [NUM_PORTS*LINES_PER_PORT-1:0] raw_in,
    input logic [NUM_PORTS*LINES_PER_PORT-1:0] filt_out,
    input logic                                tick
);
    localparam int NL = NUM_PORTS * LINES_PER_PORT;

    logic [NL-1:0] msk_sh;
    ivl_t          ivl_sh;
    int            tgap;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            msk_sh <= '0;
            ivl_sh <= '0;
            tgap   <= 0;
        end else begin
            tgap <= tick ? 0 : tgap + 1;
            if (wr_en && wr_addr == ADDR_W'(0)) ivl_sh <= wr_data[IVL_W-1:0];
            for (int p = 0; p < NUM_PORTS; p++)
                if (wr_en && wr_addr == ADDR_W'(1 + p))
                    msk_sh[p*8 +: 8] <= wr_data[7:0];
        end
    end

    AST_TICK_SPACING: assert property (@(posedge clk) disable iff (!rst_n)
        tick |-> tgap == TICK_CYC - 1); // R2
    AST_TICK_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        tgap <= TICK_CYC - 1); // R2

    for (genvar i = 0; i < NL; i++) begin : g_ln
        AST_PASS_THRU: assert property (@(posedge clk) disable iff (!rst_n)
            (!msk_sh[i] || ivl_sh == '0) |-> filt_out[i] == raw_in[i]); // R3 R4
        AST_STEP_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
            (msk_sh[i] && $past(msk_sh[i]) && ivl_sh != '0 && $past(ivl_sh) == ivl_sh
             && filt_out[i] != $past(filt_out[i])) |-> $past(tick)); // R5
        AST_STEP_VALUE: assert property (@(posedge clk) disable iff (!rst_n)
            (msk_sh[i] && $past(msk_sh[i]) && ivl_sh != '0 && $past(ivl_sh) == ivl_sh
             && filt_out[i] != $past(filt_out[i])) |-> filt_out[i] == $past(raw_in[i])); // R5
    end
endmodule

bind glitch_filter glitch_filter_chk #(
    .NUM_PORTS(NUM_PORTS),
    .ADDR_W   (ADDR_W),
    .TICK_CYC (TICK_CYC)
) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .wr_data (wr_data),
    .raw_in  (raw_in),
    .filt_out(filt_out),
    .tick    (tick)
);

// File: tb/glitch_filter_test.sv
module glitch_filter_test;
    localparam int NL = 16;

    logic          clk = 0;
    logic          rst_n = 0;
    logic          wr_en = 0;
    logic [7:0]    wr_addr = '0;
    logic [31:0]   wr_data = '0;
    logic [NL-1:0] raw_in = '0;
    logic [NL-1:0] filt_out;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #4 clk = ~clk;

    glitch_filter #(.NUM_PORTS(2), .ADDR_W(8), .CLK_HZ(125_000_000), .TICK_HZ(5_000_000)) uut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .raw_in(raw_in), .filt_out(filt_out)
    );

    // mask | interval | raw ; lines checked = all if interval 0, else unmasked ones
    localparam logic [51:0] VECS [0:7] = '{
        {16'h0000, 20'h00000, 16'hFFFF},
        {16'h0000, 20'h00005, 16'h0F0F},
        {16'hFFFF, 20'h00000, 16'hA55A},
        {16'h00FF, 20'h00000, 16'h5AA5},
        {16'h00F0, 20'h00400, 16'h3C3C},
        {16'hFF00, 20'h00400, 16'h1248},
        {16'h8001, 20'hFFFFF, 16'h7FFE},
        {16'h0000, 20'h00003, 16'h0000}
    };

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 0;
    endtask

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=%h expected=%h", 0, 1);
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        wait_cyc(3);
        rst_n = 1;
        @(negedge clk);
        raw_in = 16'hA5C3;
        #1;
        check(filt_out == raw_in, "R1 reset pass-through", filt_out, raw_in);

        // vector walk
        for (int k = 0; k < 8; k++) begin
            logic [15:0] m, r, sel;
            logic [19:0] iv;
            {m, iv, r} = VECS[k];
            wr(8'd1, {24'h0, m[7:0]});
            wr(8'd2, {24'h0, m[15:8]});
            wr(8'd0, {12'h0, iv});
            @(negedge clk);
            raw_in = r;
            #1;
            sel = (iv == 0) ? 16'hFFFF : ~m;
            check((filt_out & sel) == (r & sel), (iv == 0) ? "R4 zero interval pass" : "R3 disabled pass",
                  filt_out & sel, r & sel);
        end

        // directed: interval 4, line0 filtered
        wr(8'd1, 32'h0); wr(8'd2, 32'h0); wr(8'd0, 32'd4);
        @(negedge clk); raw_in = 16'h0000;
        wait_cyc(2);
        wr(8'd1, 32'h01);
        @(negedge clk); raw_in[0] = 1'b1;
        wait_cyc(73);
        check(filt_out[0] == 1'b0, "R5 holds before interval", filt_out[0], 0);
        wait_cyc(29);
        check(filt_out[0] == 1'b1, "R5 R2 changes after interval", filt_out[0], 1);

        // R8: unfiltered neighbour in same port follows at once
        @(negedge clk); raw_in[1] = 1'b1; raw_in[0] = 1'b0;
        #1;
        check(filt_out[1] == 1'b1, "R8 raw neighbour follows", filt_out[1], 1);
        check(filt_out[0] == 1'b1, "R8 filtered line holds", filt_out[0], 1);
        @(negedge clk); raw_in[0] = 1'b1;
        wait_cyc(2);

        // R6: glitches shorter than interval 6 with restart between
        wr(8'd0, 32'd6);
        @(negedge clk); raw_in[0] = 1'b0;
        wait_cyc(100);
        check(filt_out[0] == 1'b1, "R6 first glitch suppressed", filt_out[0], 1);
        raw_in[0] = 1'b1;
        wait_cyc(5);
        raw_in[0] = 1'b0;
        wait_cyc(100);
        check(filt_out[0] == 1'b1, "R6 count restarted", filt_out[0], 1);
        raw_in[0] = 1'b1;
        wait_cyc(10);
        check(filt_out[0] == 1'b1, "R6 level kept", filt_out[0], 1);

        // R7: upper bits ignored, interval 2
        wr(8'd0, 32'hFFF00002);
        @(negedge clk); raw_in[0] = 1'b0;
        wait_cyc(23);
        check(filt_out[0] == 1'b1, "R7 holds before 2 ticks", filt_out[0], 1);
        wait_cyc(29);
        check(filt_out[0] == 1'b0, "R7 interval uses low 20 bits", filt_out[0], 0);

        // R2: interval 1 reacts within one tick period
        wr(8'd0, 32'd1);
        @(negedge clk); raw_in[0] = 1'b1;
        wait_cyc(27);
        check(filt_out[0] == 1'b1, "R2 one tick interval", filt_out[0], 1);

        // R9: enabling line2 while raw is high
        wr(8'd0, 32'd6);
        @(negedge clk); raw_in[2] = 1'b1;
        wait_cyc(2);
        wr(8'd1, 32'h05);
        #1;
        check(filt_out[2] == 1'b1, "R9 starts from raw", filt_out[2], 1);
        wait_cyc(100);
        check(filt_out[2] == 1'b1, "R9 no spurious change", filt_out[2], 1);

        // R10: unmapped write leaves masks and interval unchanged
        wr(8'h3F, 32'hFFFFFFFF);
        @(negedge clk); raw_in[3] = 1'b1; raw_in[9] = 1'b1;
        #1;
        check(filt_out[3] == 1'b1 && filt_out[9] == 1'b1, "R10 unmapped write ignored",
              {filt_out[9], filt_out[3]}, 2'b11);
        @(negedge clk); raw_in[2] = 1'b0;
        wait_cyc(100);
        check(filt_out[2] == 1'b1, "R10 interval kept", filt_out[2], 1);

        // R4 directed: interval 0 on enabled line
        wr(8'd0, 32'd0);
        @(negedge clk); raw_in[0] = 1'b0;
        #1;
        check(filt_out[0] == 1'b0, "R4 enabled zero interval", filt_out[0], 0);

        // R1 again after a second reset
        @(negedge clk); rst_n = 0;
        wait_cyc(2);
        rst_n = 1; raw_in = 16'h6B1D;
        #1;
        check(filt_out == 16'h6B1D, "R1 masks cleared", filt_out, 16'h6B1D);

        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule